// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit linear address into a 32-bit physical address. It reads one entry from a page directory and one entry from a page table in memory. The linear address is split into a 10-bit directory index, a 10-bit table index and a 12-bit page offset, so pages are 4 KB. A base register input gives the physical location of the directory. All memory traffic goes through one 32-bit request/valid port, and only one walk is in flight at a time.

After both entries are read, the walker checks their present bits. It then checks the permission bits of both levels against the privilege (user or supervisor) and the direction (read or write) of the access. A walk that fails ends with a fault report: the failing level, the fault kind and the access attributes. A walk that succeeds returns the physical address. Before it finishes, it writes back the accessed flag of each entry that had it clear, and on a write it also sets the dirty flag of the table entry.

Top module: `pt_walker`

## Requirements
- R1: The directory entry is read at {base[31:12], va[31:22], 2'b00}. The table entry is read at {pde[31:12], va[21:12], 2'b00}, where pde is the directory entry just read.
- R2: A successful walk sets fault_o=0 and paddr_o={pte[31:12], va[11:0]}.
- R3: If the directory entry has present (bit 0) clear, the walk ends with fault_o=1, fault_level_o=0 (directory) and fault_prot_o=0 (not present). The table entry is not read and nothing is written.
- R4: If the table entry has present (bit 0) clear, the walk ends with fault_o=1, fault_level_o=1 (table) and fault_prot_o=0. Nothing is written.
- R5: For a user access, each level allows the access only if its user bit (bit 2) is set and, for a write, its writable bit (bit 1) is also set. Both levels must allow the access. Otherwise the walk faults with fault_prot_o=1, and fault_level_o names the directory (0) if the directory denies, or the table (1) if it does not. Nothing is written.
- R6: A supervisor access (req_user_i=0) is never denied for permission, whatever bits 1 and 2 hold.
- R7: On success, each entry whose accessed bit (bit 5) is clear is written back with that bit set: first the directory entry, then the table entry. An entry that needs no change is not written.
- R8: On a successful write access, the table entry is written with dirty (bit 6) set if it was clear. A read access never changes bit 6.
- R9: On a fault, fault_addr_o shows the linear address, fault_write_o shows the access direction and fault_user_o shows the privilege of the faulting request.
- R10: req_ready_o is high only when no walk is active. done_o is a single-cycle pulse that ends each walk. A memory request keeps its address, data and direction until mem_valid_i is seen.
- R11: After reset, req_ready_o=1, mem_req_o=0 and done_o=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Start a walk (taken when req_ready_o is high) |
| req_ready_o | output | 1 | Walker idle |
| req_vaddr_i | input | 32 | Linear address |
| req_write_i | input | 1 | 1 = write access |
| req_user_i | input | 1 | 1 = user privilege |
| dir_base_i | input | 32 | Directory physical base (bits 31:12 used) |
| mem_req_o | output | 1 | Memory request active |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | 32 | Memory address |
| mem_wdata_o | output | 32 | Write data |
| mem_valid_i | input | 1 | Request completed; read data valid |
| mem_rdata_i | input | 32 | Read data |
| done_o | output | 1 | Walk finished (one-cycle pulse) |
| fault_o | output | 1 | Walk ended in a fault |
| fault_level_o | output | 1 | Faulting level: 0 directory, 1 table |
| fault_prot_o | output | 1 | 1 = permission fault, 0 = not present |
| fault_addr_o | output | 32 | Linear address of the walk |
| fault_write_o | output | 1 | Direction of the walk |
| fault_user_o | output | 1 | Privilege of the walk |
| paddr_o | output | 32 | Physical address |

## Verification
Some properties are checked on every cycle. A memory request holds steady until it completes. No request is issued while the walker is idle. done_o lasts one cycle. Every write-back carries the accessed bit, and a read walk never changes the dirty bit. On success the offset reaches paddr_o unchanged. A supervisor access always passes the permission logic. Other behaviour depends on the contents of memory, and only the bench scenarios show it. These scenarios cover the exact address sequence, the order and values of the write-backs, the level reported by each kind of fault, and the choice of the stricter of the two permission levels.

// File: rtl/pw_pkg.sv
package pw_pkg;
  localparam int unsigned ADDR_W  = 32;
  localparam int unsigned OFF_W   = 12;
  localparam int unsigned IDX_W   = 10;
  localparam int unsigned FRAME_W = ADDR_W - OFF_W;
  localparam int unsigned DIR_LO  = OFF_W + IDX_W;

  localparam int unsigned BIT_P = 0;
  localparam int unsigned BIT_W = 1;
  localparam int unsigned BIT_U = 2;
  localparam int unsigned BIT_A = 5;
  localparam int unsigned BIT_D = 6;

  localparam logic LVL_DIR = 1'b0;
  localparam logic LVL_TBL = 1'b1;

  typedef enum logic [2:0] {
    ST_IDLE, ST_READ_PDE, ST_READ_PTE, ST_UPDATE_PDE, ST_UPDATE_PTE, ST_DONE
  } pw_state_e;

  typedef struct packed {
    logic [FRAME_W-1:0] frame;
    logic               dirty;
    logic               accessed;
    logic               user;
    logic               writable;
    logic               present;
  } pw_entry_t;
endpackage

// File: rtl/pw_entry_decode.sv
module pw_entry_decode
  import pw_pkg::*;
(
  input  logic [ADDR_W-1:0] word_i,
  output pw_entry_t         ent_o
);
  assign ent_o.frame    = word_i[ADDR_W-1:OFF_W];
  assign ent_o.dirty    = word_i[BIT_D];
  assign ent_o.accessed = word_i[BIT_A];
  assign ent_o.user     = word_i[BIT_U];
  assign ent_o.writable = word_i[BIT_W];
  assign ent_o.present  = word_i[BIT_P];
endmodule

// File: rtl/pw_perm_check.sv
module pw_perm_check
  import pw_pkg::*;
(
  input  pw_entry_t dir_i,
  input  pw_entry_t tbl_i,
  input  logic      user_i,
  input  logic      write_i,
  output logic      allow_o,
  output logic      deny_lvl_o
);
  localparam int unsigned NLVL = 2;

  pw_entry_t lvl [NLVL];
  logic [NLVL-1:0] ok;

  assign lvl[0] = dir_i;
  assign lvl[1] = tbl_i;

  for (genvar g = 0; g < NLVL; g++) begin : g_lvl
    assign ok[g] = !user_i || (lvl[g].user && (!write_i || lvl[g].writable));
  end

  assign allow_o    = &ok;
  assign deny_lvl_o = ok[0] ? LVL_TBL : LVL_DIR;

  always_comb begin
    if (user_i && !dir_i.user) a_r5_dir_user_deny: assert (!allow_o && deny_lvl_o == LVL_DIR);
  end
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import pw_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [ADDR_W-1:0] req_vaddr_i,
  input  logic              req_write_i,
  input  logic              req_user_i,
  input  logic [ADDR_W-1:0] dir_base_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [ADDR_W-1:0] mem_wdata_o,
  input  logic              mem_valid_i,
  input  logic [ADDR_W-1:0] mem_rdata_i,
  output logic              done_o,
  output logic              fault_o,
  output logic              fault_level_o,
  output logic              fault_prot_o,
  output logic [ADDR_W-1:0] fault_addr_o,
  output logic              fault_write_o,
  output logic              fault_user_o,
  output logic [ADDR_W-1:0] paddr_o
);
  pw_state_e           state_q;
  logic [ADDR_W-1:0]   va_q, pde_q, pte_q, paddr_q;
  logic [FRAME_W-1:0]  base_q;
  logic                wr_q, usr_q;
  logic                fault_q, fault_lvl_q, fault_prot_q;

  // decode the stored directory entry and the live read data
  logic [ADDR_W-1:0] dec_word [2];
  pw_entry_t         dec_ent  [2];
  assign dec_word[0] = pde_q;
  assign dec_word[1] = mem_rdata_i;
  for (genvar g = 0; g < 2; g++) begin : g_dec
    pw_entry_decode u_dec (.word_i(dec_word[g]), .ent_o(dec_ent[g]));
  end

  pw_entry_t pde_ent, rd_ent;
  assign pde_ent = dec_ent[0];
  assign rd_ent  = dec_ent[1];

  logic allow, deny_lvl;
  pw_perm_check u_perm (
    .dir_i     (pde_ent),
    .tbl_i     (rd_ent),
    .user_i    (usr_q),
    .write_i   (wr_q),
    .allow_o   (allow),
    .deny_lvl_o(deny_lvl)
  );

  function automatic logic pte_needs_wb(input logic [ADDR_W-1:0] e, input logic wr);
    return !e[BIT_A] || (wr && !e[BIT_D]);
  endfunction

  logic [ADDR_W-1:0] pde_addr, pte_addr;
  assign pde_addr = {base_q, va_q[ADDR_W-1:DIR_LO], 2'b00};
  assign pte_addr = {pde_q[ADDR_W-1:OFF_W], va_q[DIR_LO-1:OFF_W], 2'b00};

  logic [ADDR_W-1:0] a_mask, d_mask;
  assign a_mask = ADDR_W'(1) << BIT_A;
  assign d_mask = ADDR_W'(1) << BIT_D;

  always_comb begin
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = pde_addr;
    mem_wdata_o = '0;
    unique case (state_q)
      ST_READ_PDE: mem_req_o = 1'b1;
      ST_READ_PTE: begin
        mem_req_o  = 1'b1;
        mem_addr_o = pte_addr;
      end
      ST_UPDATE_PDE: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_wdata_o = pde_q | a_mask;
      end
      ST_UPDATE_PTE: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = pte_addr;
        mem_wdata_o = pte_q | a_mask | (wr_q ? d_mask : '0);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_IDLE;
      va_q         <= '0;
      pde_q        <= '0;
      pte_q        <= '0;
      paddr_q      <= '0;
      base_q       <= '0;
      wr_q         <= 1'b0;
      usr_q        <= 1'b0;
      fault_q      <= 1'b0;
      fault_lvl_q  <= LVL_DIR;
      fault_prot_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (req_valid_i) begin
          va_q         <= req_vaddr_i;
          wr_q         <= req_write_i;
          usr_q        <= req_user_i;
          base_q       <= dir_base_i[ADDR_W-1:OFF_W];
          fault_q      <= 1'b0;
          fault_lvl_q  <= LVL_DIR;
          fault_prot_q <= 1'b0;
          state_q      <= ST_READ_PDE;
        end
        ST_READ_PDE: if (mem_valid_i) begin
          pde_q <= mem_rdata_i;
          if (!rd_ent.present) begin
            fault_q     <= 1'b1;
            fault_lvl_q <= LVL_DIR;
            state_q     <= ST_DONE;
          end else begin
            state_q <= ST_READ_PTE;
          end
        end
        ST_READ_PTE: if (mem_valid_i) begin
          pte_q <= mem_rdata_i;
          if (!rd_ent.present) begin
            fault_q     <= 1'b1;
            fault_lvl_q <= LVL_TBL;
            state_q     <= ST_DONE;
          end else if (!allow) begin
            fault_q      <= 1'b1;
            fault_prot_q <= 1'b1;
            fault_lvl_q  <= deny_lvl;
            state_q      <= ST_DONE;
          end else begin
            paddr_q <= {rd_ent.frame, va_q[OFF_W-1:0]};
            if (!pde_ent.accessed)                 state_q <= ST_UPDATE_PDE;
            else if (pte_needs_wb(mem_rdata_i, wr_q)) state_q <= ST_UPDATE_PTE;
            else                                   state_q <= ST_DONE;
          end
        end
        ST_UPDATE_PDE: if (mem_valid_i)
          state_q <= pte_needs_wb(pte_q, wr_q) ? ST_UPDATE_PTE : ST_DONE;
        ST_UPDATE_PTE: if (mem_valid_i) state_q <= ST_DONE;
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready_o   = (state_q == ST_IDLE);
  assign done_o        = (state_q == ST_DONE);
  assign fault_o       = fault_q;
  assign fault_level_o = fault_lvl_q;
  assign fault_prot_o  = fault_prot_q;
  assign fault_addr_o  = va_q;
  assign fault_write_o = wr_q;
  assign fault_user_o  = usr_q;
  assign paddr_o       = paddr_q;

  a_r10_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_valid_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)
                                  && $stable(mem_wdata_o));
  a_r10_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r10_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_ready_o && mem_req_o));
  a_r7_wb_accessed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> mem_wdata_o[BIT_A]);
  a_r8_read_keeps_dirty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_UPDATE_PTE && !wr_q) |-> mem_wdata_o[BIT_D] == pte_q[BIT_D]);
  a_r2_offset_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !fault_o |-> paddr_o[OFF_W-1:0] == fault_addr_o[OFF_W-1:0]);
  a_r6_supervisor_ok: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !fault_user_o |-> !fault_prot_o);
endmodule

// File: tb/sim_pt_walker.sv
module sim_pt_walker;
  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic req_valid = 0, req_ready, req_write = 0, req_user = 0;
  logic [31:0] req_vaddr = 0, dir_base = 32'h0001_0000;
  logic mem_req, mem_we, mem_valid = 0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = 0;
  logic done, fault, flvl, fprot, fwr, fusr;
  logic [31:0] faddr, paddr;

  pt_walker u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_vaddr_i(req_vaddr),
    .req_write_i(req_write), .req_user_i(req_user), .dir_base_i(dir_base),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_valid_i(mem_valid), .mem_rdata_i(mem_rdata),
    .done_o(done), .fault_o(fault), .fault_level_o(flvl), .fault_prot_o(fprot),
    .fault_addr_o(faddr), .fault_write_o(fwr), .fault_user_o(fusr), .paddr_o(paddr)
  );

  int checks = 0, fails = 0, cyc = 0, lat = 0, wcnt = 0;
  logic [31:0] mem [int unsigned];
  logic [31:0] rd_q[$], wa_q[$], wd_q[$];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      fails++; checks++;
      $display("FAIL watchdog act=%0d exp=0", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  // memory responder
  always @(negedge clk) begin
    if (mem_valid) begin
      mem_valid = 0;
      wcnt = 0;
    end else if (mem_req) begin
      if (wcnt >= lat) begin
        mem_valid = 1;
        wcnt = 0;
        if (mem_we) begin
          mem[mem_addr] = mem_wdata;
          wa_q.push_back(mem_addr);
          wd_q.push_back(mem_wdata);
        end else begin
          mem_rdata = mem.exists(mem_addr) ? mem[mem_addr] : 32'h0;
          rd_q.push_back(mem_addr);
        end
      end else wcnt++;
    end
  end

  function automatic logic [31:0] pde_a(input logic [31:0] va);
    return {dir_base[31:12], va[31:22], 2'b00};
  endfunction
  function automatic logic [31:0] pte_a(input logic [31:0] pde, input logic [31:0] va);
    return {pde[31:12], va[21:12], 2'b00};
  endfunction

  task automatic setup(input logic [31:0] va, input logic [31:0] pde, input logic [31:0] pte);
    mem.delete();
    mem[pde_a(va)] = pde;
    mem[pte_a(pde, va)] = pte;
    rd_q.delete(); wa_q.delete(); wd_q.delete();
  endtask

  task automatic walk(input logic [31:0] va, input bit w, input bit u);
    int n = 0;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_vaddr = va; req_write = w; req_user = u;
    @(negedge clk);
    req_valid = 0;
    chk(!req_ready, "R10 busy", 32'(req_ready), 0);
    while (!done && n < 1000) begin @(negedge clk); n++; end
    chk(done, "R10 done", 32'(done), 1);
    @(negedge clk);
    chk(!done, "R10 pulse", 32'(done), 0);
  endtask

  task automatic t_reset;
    chk(req_ready, "R11 ready", 32'(req_ready), 1);
    chk(!mem_req, "R11 mem_req", 32'(mem_req), 0);
    chk(!done, "R11 done", 32'(done), 0);
  endtask

  task automatic t_basic;
    logic [31:0] va = 32'h1234_5678;
    lat = 0;
    setup(va, 32'h0002_0027, 32'h000A_B067);
    walk(va, 0, 0);
    chk(rd_q.size() == 2, "R1 reads", rd_q.size(), 2);
    chk(rd_q[0] == pde_a(va), "R1 pde addr", rd_q[0], pde_a(va));
    chk(rd_q[1] == pte_a(32'h0002_0027, va), "R1 pte addr", rd_q[1], pte_a(32'h0002_0027, va));
    chk(!fault, "R2 fault", 32'(fault), 0);
    chk(paddr == 32'h000A_B678, "R2 paddr", paddr, 32'h000A_B678);
    chk(wa_q.size() == 0, "R7 no wb", wa_q.size(), 0);
  endtask

  task automatic t_accessed;
    logic [31:0] va = 32'h8040_1ABC;
    logic [31:0] pde = 32'h0003_0007;
    lat = 2;
    setup(va, pde, 32'h000C_D007);
    walk(va, 0, 0);
    chk(wa_q.size() == 2, "R7 wb count", wa_q.size(), 2);
    if (wa_q.size() == 2) begin
      chk(wa_q[0] == pde_a(va), "R7 first pde", wa_q[0], pde_a(va));
      chk(wd_q[0] == 32'h0003_0027, "R7 pde data", wd_q[0], 32'h0003_0027);
      chk(wa_q[1] == pte_a(pde, va), "R7 pte addr", wa_q[1], pte_a(pde, va));
      chk(wd_q[1] == 32'h000C_D027, "R8 read no dirty", wd_q[1], 32'h000C_D027);
    end
    chk(paddr == 32'h000C_DABC, "R2 paddr2", paddr, 32'h000C_DABC);
  endtask

  task automatic t_dirty;
    logic [31:0] va = 32'h0040_2010;
    logic [31:0] pde = 32'h0004_0027;
    lat = 1;
    setup(va, pde, 32'h0005_5027);
    walk(va, 1, 0);
    chk(wa_q.size() == 1, "R8 wb count", wa_q.size(), 1);
    if (wa_q.size() == 1)
      chk(wa_q[0] == pte_a(pde, va) && wd_q[0] == 32'h0005_5067, "R8 dirty set", wd_q[0], 32'h0005_5067);
    setup(va, pde, 32'h0005_5027);
    walk(va, 0, 1);
    chk(wa_q.size() == 0 && !fault, "R8 read leaves dirty", wa_q.size(), 0);
  endtask

  task automatic t_pde_np;
    logic [31:0] va = 32'h0040_0ABC;
    lat = 1;
    setup(va, 32'h0002_0006, 32'h0000_0027);
    walk(va, 1, 1);
    chk(fault && !flvl && !fprot, "R3 kind", {29'd0, fault, flvl, fprot}, 32'h4);
    chk(rd_q.size() == 1 && wa_q.size() == 0, "R3 traffic", rd_q.size() + wa_q.size(), 1);
    chk(faddr == va, "R9 addr", faddr, va);
    chk(fwr && fusr, "R9 attrs", {fwr, fusr}, 2'b11);
  endtask

  task automatic t_pte_np;
    logic [31:0] va = 32'hFFC0_0123;
    lat = 0;
    setup(va, 32'h0002_0027, 32'h0009_9026);
    walk(va, 0, 0);
    chk(fault && flvl && !fprot, "R4 kind", {29'd0, fault, flvl, fprot}, 32'h6);
    chk(wa_q.size() == 0, "R4 no wb", wa_q.size(), 0);
    chk(!fwr && !fusr && faddr == va, "R9 read attrs", faddr, va);
  endtask

  task automatic t_user;
    logic [31:0] va = 32'h0080_3444;
    lat = 1;
    setup(va, 32'h0002_0023, 32'h0007_7067);
    walk(va, 0, 1);
    chk(fault && fprot && !flvl, "R5 dir no user", {29'd0, fault, flvl, fprot}, 32'h5);
    setup(va, 32'h0002_0027, 32'h0007_7065);
    walk(va, 1, 1);
    chk(fault && fprot && flvl, "R5 tbl read-only", {29'd0, fault, flvl, fprot}, 32'h7);
    chk(wa_q.size() == 0, "R5 no wb", wa_q.size(), 0);
    setup(va, 32'h0002_0027, 32'h0007_7065);
    walk(va, 0, 1);
    chk(!fault && paddr == 32'h0007_7444, "R5 user read ok", paddr, 32'h0007_7444);
    setup(va, 32'h0002_0025, 32'h0007_7067);
    walk(va, 1, 1);
    chk(fault && fprot && !flvl, "R5 stricter dir", {29'd0, fault, flvl, fprot}, 32'h5);
  endtask

  task automatic t_super;
    logic [31:0] va = 32'h0C00_5FFF;
    lat = 2;
    setup(va, 32'h0002_0021, 32'h0001_1061);
    walk(va, 1, 0);
    chk(!fault && paddr == 32'h0001_1FFF, "R6 supervisor write", paddr, 32'h0001_1FFF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_accessed();
    t_dirty();
    t_pde_np();
    t_pte_np();
    t_user();
    t_super();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule